// File: doc/BRIEF.md
# Bus Wake-Up Filter

This block recognises a remote wake-up on a single-wire vehicle bus while the transceiver sits in a low-power state. It receives the digitised bus level, where 0 means dominant and 1 means recessive. It also receives a flag that is high in the silent and sleep states, a gate from the pre-wake comparator, a one-microsecond tick and a filter time in microseconds. When a valid dominant pulse ends, it raises a single-cycle wake request.

A valid pulse starts with a falling edge and stays dominant for at least the filter time. It must then end with a rising edge. The request is issued on that closing rising edge, not at the moment the filter time runs out. Pulses that are too short are discarded. A dominant level that is already present when the low-power state begins does not count as a pulse.

The bus level is taken through a two-stage synchroniser. The filter time is counted in tick periods, so the request also depends on the tick rate supplied.

Top module: `lin_wake_filter`

## Requirements
- R1: During and directly after synchronous reset, `wake_req_o` is 0.
- R2: The bus input passes through two synchronising flip-flops. A valid rising edge therefore raises `wake_req_o` in the cycle after the third rising clock edge at which `bus_rx_i` is sampled as 1.
- R3: A pulse qualifies when it starts with a 1-to-0 transition of the synchronised bus and holds 0 for at least the filter time, counted as `tick_us_i` pulses seen while dominant. The 0-to-1 transition that ends a qualifying pulse produces a wake request.
- R4: A pulse that returns to 1 before the filter time is reached produces no request, and the event is discarded.
- R5: The filter time is `filt_us_i` clamped into the range 30 to 150 microseconds. A smaller value acts as 30, and a larger value acts as 150.
- R6: Requests are produced only while both `lowpwr_i` and `prewake_en_i` are 1.
- R7: A dominant level present when the block becomes active is ignored until the bus has been recessive and a new falling edge is seen.
- R8: When `lowpwr_i` or `prewake_en_i` falls, the counter and any pulse in progress are cleared. `wake_req_o` is 0 in the following cycle.
- R9: `wake_req_o` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rx_i | input | 1 | Digitised bus level, 0 = dominant |
| lowpwr_i | input | 1 | High while in a silent or sleep state |
| prewake_en_i | input | 1 | Gate from the pre-wake comparator |
| tick_us_i | input | 1 | One-cycle pulse once per microsecond |
| filt_us_i | input | 8 | Requested filter time in microseconds |
| wake_req_o | output | 1 | One-cycle wake request |

## Verification
The hardest cases to reach from the ports involve the moment the block becomes active. One is a dominant level that is already present on entry. The other is the low-power flag dropping in the middle of a qualified pulse. The stimulus holds the bus dominant across the rising edge of `lowpwr_i` and keeps it there well beyond the filter time before releasing it. In the second case it drops and raises the flag while the pulse continues and only then ends the pulse. The clamp limits are reached by programming filter values outside 30..150 and sending pulses just below and just above each clamped limit.

// File: rtl/lwf_pkg.sv
package lwf_pkg;
    parameter int FILT_W  = 8;
    parameter int MIN_US  = 30;
    parameter int MAX_US  = 150;

    typedef enum logic [1:0] {
        ST_WAIT_REC = 2'd0,
        ST_IDLE     = 2'd1,
        ST_DOM      = 2'd2
    } wk_state_e;

    typedef struct packed {
        logic level;
        logic fall;
        logic rise;
    } bus_ev_t;

    function automatic logic [FILT_W-1:0] clamp_filt(input logic [FILT_W-1:0] v);
        if (v < FILT_W'(MIN_US))      return FILT_W'(MIN_US);
        else if (v > FILT_W'(MAX_US)) return FILT_W'(MAX_US);
        else                          return v;
    endfunction
endpackage

// File: rtl/lwf_sync.sv
module lwf_sync
    import lwf_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    bus_i,
    output bus_ev_t ev_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], bus_i};
            prev_q <= sync_q[STAGES-1];
        end
    end

    always_comb begin
        ev_o.level = sync_q[STAGES-1];
        ev_o.fall  = prev_q & ~sync_q[STAGES-1];
        ev_o.rise  = ~prev_q & sync_q[STAGES-1];
    end
endmodule

// File: rtl/lwf_timer.sv
module lwf_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             run,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_o <= '0;
        else if (run && tick && cnt_o != CNT_MAX)
            cnt_o <= cnt_o + 1'b1;
    end
endmodule

// File: rtl/lwf_ctrl.sv
module lwf_ctrl
    import lwf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      active,
    input  bus_ev_t   ev,
    input  logic      qual,
    output wk_state_e state_o,
    output logic      clr_o,
    output logic      req_o
);
    wk_state_e state_q;

    assign state_o = state_q;
    assign clr_o   = ~active | (state_q == ST_IDLE && ev.fall);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            state_q <= ST_WAIT_REC;
            req_o   <= 1'b0;
        end else begin
            req_o <= 1'b0;
            case (state_q)
                ST_WAIT_REC: if (ev.level) state_q <= ST_IDLE;
                ST_IDLE:     if (ev.fall)  state_q <= ST_DOM;
                ST_DOM: begin
                    if (ev.rise) begin
                        req_o   <= qual;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_WAIT_REC;
            endcase
        end
    end
endmodule

// File: rtl/lin_wake_filter.sv
module lin_wake_filter
    import lwf_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rx_i,
    input  logic              lowpwr_i,
    input  logic              prewake_en_i,
    input  logic              tick_us_i,
    input  logic [FILT_W-1:0] filt_us_i,
    output logic              wake_req_o
);
    bus_ev_t           ev;
    wk_state_e         state;
    logic              clr;
    logic              active;
    logic              bus_s;
    logic [CNT_W-1:0]  dom_cnt;
    logic [FILT_W-1:0] lim;

    assign active = lowpwr_i & prewake_en_i;
    assign lim    = clamp_filt(filt_us_i);
    assign bus_s  = ev.level;

    lwf_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .bus_i(bus_rx_i), .ev_o(ev)
    );

    lwf_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .clr(clr), .run(state == ST_DOM),
        .tick(tick_us_i), .cnt_o(dom_cnt)
    );

    lwf_ctrl u_ctrl (
        .clk(clk), .rst(rst), .active(active), .ev(ev),
        .qual(32'(dom_cnt) >= 32'(lim)),
        .state_o(state), .clr_o(clr), .req_o(wake_req_o)
    );
endmodule

// File: rtl/lwf_chk.sv
module lwf_chk #(
    parameter int CNT_W  = 8,
    parameter int FILT_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              lowpwr_i,
    input logic              prewake_en_i,
    input logic              wake_req_o,
    input logic              bus_s,
    input logic [CNT_W-1:0]  dom_cnt,
    input logic [FILT_W-1:0] lim
);
    p_one_cycle_r9: assert property (@(posedge clk) disable iff (rst)
        wake_req_o |=> !wake_req_o);

    p_gated_r6: assert property (@(posedge clk) disable iff (rst)
        wake_req_o |-> $past(lowpwr_i && prewake_en_i));

    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        !(lowpwr_i && prewake_en_i) |=> !wake_req_o);

    p_on_rise_r3: assert property (@(posedge clk) disable iff (rst)
        wake_req_o |-> $past(bus_s));

    p_min_len_r4: assert property (@(posedge clk) disable iff (rst)
        wake_req_o |-> $past(32'(dom_cnt) >= 32'(lim)));
endmodule

bind lin_wake_filter lwf_chk #(.CNT_W(CNT_W), .FILT_W(lwf_pkg::FILT_W)) u_chk (.*);

// File: tb/tb_lin_wake_filter.sv
module tb_lin_wake_filter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_rx_i = 1'b1;
    logic       lowpwr_i = 1'b0;
    logic       prewake_en_i = 1'b0;
    logic       tick_us_i = 1'b0;
    logic [7:0] filt_us_i = 8'd90;
    logic       wake_req_o;

    int tests = 0, fails = 0, req_cnt = 0, tdiv = 0;
    int exp_q[$];
    string tag_q[$];

    lin_wake_filter dut (.*);

    always #5 clk = ~clk;

    always @(negedge clk) begin
        tdiv      = (tdiv == 9) ? 0 : tdiv + 1;
        tick_us_i <= (tdiv == 0);
        if (!rst && wake_req_o) req_cnt++;
    end

    initial begin
        #2_000_000;
        fails++; tests++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic chk(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // driver: pushes the expected number of requests for one pulse
    task automatic pulse(int us, int exp, string tag);
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk); bus_rx_i = 1'b0;
        repeat (us * 10) @(negedge clk);
        bus_rx_i = 1'b1;
        repeat (20) @(negedge clk);
        monitor_pop();
    endtask

    // monitor: pops the expectation and compares it with the observed requests
    task automatic monitor_pop();
        int e = exp_q.pop_front();
        string t = tag_q.pop_front();
        chk(t, req_cnt, e);
        req_cnt = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset", int'(wake_req_o), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset", int'(wake_req_o), 0);
        lowpwr_i = 1'b1; prewake_en_i = 1'b1;
        repeat (5) @(negedge clk);

        // R2: exact timing of the request after release
        @(negedge clk); bus_rx_i = 1'b0;
        repeat (1000) @(negedge clk);
        bus_rx_i = 1'b1;
        @(negedge clk); chk("R2 edge1", int'(wake_req_o), 0);
        @(negedge clk); chk("R2 edge2", int'(wake_req_o), 0);
        @(negedge clk); chk("R2 edge3 req", int'(wake_req_o), 1);
        @(negedge clk); chk("R9 single cycle", int'(wake_req_o), 0);
        repeat (10) @(negedge clk); req_cnt = 0;

        pulse(100, 1, "R3 100us qualifies");
        pulse(80, 0, "R4 80us rejected");
        pulse(5, 0, "R4 glitch rejected");
        filt_us_i = 8'd40;
        pulse(45, 1, "R5 40us filter pass");
        pulse(35, 0, "R5 40us filter short");
        filt_us_i = 8'd10;
        pulse(20, 0, "R5 low clamp short");
        pulse(35, 1, "R5 low clamp pass");
        filt_us_i = 8'd200;
        pulse(140, 0, "R5 high clamp short");
        pulse(160, 1, "R5 high clamp pass");
        filt_us_i = 8'd90;

        prewake_en_i = 1'b0;
        pulse(100, 0, "R6 prewake off");
        prewake_en_i = 1'b1; lowpwr_i = 1'b0;
        pulse(100, 0, "R6 normal mode");

        // R7: dominant already present on entry
        @(negedge clk); bus_rx_i = 1'b0;
        repeat (50) @(negedge clk);
        lowpwr_i = 1'b1;
        exp_q.push_back(0); tag_q.push_back("R7 dominant on entry");
        repeat (1500) @(negedge clk);
        bus_rx_i = 1'b1;
        repeat (20) @(negedge clk);
        monitor_pop();

        // R8: flag drops in the middle of a qualified pulse
        exp_q.push_back(0); tag_q.push_back("R8 cleared on exit");
        @(negedge clk); bus_rx_i = 1'b0;
        repeat (1200) @(negedge clk);
        lowpwr_i = 1'b0;
        @(negedge clk); @(negedge clk);
        lowpwr_i = 1'b1;
        repeat (1200) @(negedge clk);
        bus_rx_i = 1'b1;
        repeat (20) @(negedge clk);
        monitor_pop();

        pulse(100, 1, "R3 recovers after R8");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule